// File: doc/BRIEF.md
# Triple-Redundant Voted Up/Down Counter

This block is a small sequential controller, a wrapping up/down counter, built as three identical copies called domains. Each domain has its own clock, its own active-low reset and its own copies of the enable and direction inputs. Each domain has its own bitwise majority voter at the head of its feedback loop. Every domain computes its next count from the voted value of all three state registers and never from its own register alone.

A single corrupted domain is therefore outvoted on the next clock edge and loads the same value as the other two. It heals with no reset and no command from outside. The corruption can come from a wrong register value, a domain held in reset, or a domain whose inputs disagree. A test-only fault-injection port can force or flip the register of one selected domain for one clock. Each domain's register and a per-domain disagreement flag are brought out for observation.

Top module: `tmr_voted_ctrl`

## Requirements
- R1: A domain whose reset input is low holds the value 0. After all resets are released together, the three registers hold identical values.
- R2: When the three registers agree and every domain sees enable=1 and up=1, each register advances by one. From MAX_COUNT-1 it wraps to 0.
- R3: When the three registers agree and every domain sees enable=1 and up=0, each register decreases by one. From 0 it wraps to MAX_COUNT-1.
- R4: With enable=0 in every domain and no injection, all registers keep their value.
- R5: Each domain's next value is computed from the bitwise majority (a&b)|(b&c)|(a&c) of the three registers, taken separately for every bit.
- R6: When the injection enable is high and the injection mode is 0 (force), the domain named by the select input (0, 1 or 2) loads the injection value at that edge. The other two domains load their normal next value.
- R7: When the injection mode is 1 (flip), the selected domain loads its normal next value XOR the injection value.
- R8: A select value of 3 names no domain, so all three domains load their normal next value.
- R9: After any cycle with no injection, in which all domains see identical enable and direction inputs, all three registers hold the same value.
- R10: Mismatch flag k is high exactly while register k differs from the bitwise majority of the three registers.
- R11: While one domain is held in reset, the other two keep counting correctly. One edge after that domain's reset is released, it holds the same value as the other two.
- R12: If one domain's enable input disagrees with the other two, the majority of the registers still follows the inputs of the two agreeing domains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 3 | One clock per domain |
| rst_ni | input | 3 | One asynchronous active-low reset per domain |
| en_i | input | 3 | Count enable, one copy per domain |
| up_i | input | 3 | Direction (1 = up, 0 = down), one copy per domain |
| inj_en_i | input | 1 | Test-only: apply an injection at this edge |
| inj_sel_i | input | 2 | Target domain 0..2; 3 selects none |
| inj_mode_i | input | 1 | 0 = force the value, 1 = XOR it into the next value |
| inj_val_i | input | CNT_W | Injection value or XOR mask |
| state_o | output | 3 x CNT_W | Register of each domain |
| mismatch_o | output | 3 | Per-domain disagreement with the voted value |

## Verification
The bench builds the block with MAX_COUNT=12, so CNT_W=4. This count is not a power of two, so the wrap in both directions is a separate step from the natural binary rollover. Forced values 12 to 15 lie outside the counting range. These values show that an out-of-range register in one domain is outvoted and never takes over the count. The bench also makes every single-domain fault reachable: a force, a flip, a domain held in reset, and a domain with a disagreeing input. It draws them at random, on each of the three domains, and always leaves a clean cycle between faults.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned NUM_DOM = 3;

    typedef enum logic {
        INJ_FORCE = 1'b0,
        INJ_FLIP  = 1'b1
    } inj_mode_e;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] y_o
);
    // Bitwise two-of-three majority.
    assign y_o = (a_i & b_i) | (b_i & c_i) | (a_i & c_i);
endmodule

// File: rtl/tmr_domain.sv
module tmr_domain
    import tmr_pkg::*;
#(
    parameter int unsigned MAX_COUNT = 12,
    parameter int unsigned CNT_W     = $clog2(MAX_COUNT),
    parameter int unsigned DOM_IDX   = 0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          en_i,
    input  logic                          up_i,
    input  logic                          inj_en_i,
    input  logic [1:0]                    inj_sel_i,
    input  logic                          inj_mode_i,
    input  logic [CNT_W-1:0]              inj_val_i,
    input  logic [NUM_DOM-1:0][CNT_W-1:0] all_q_i,
    output logic [CNT_W-1:0]              q_o,
    output logic                          mismatch_o
);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(MAX_COUNT - 1);
    localparam logic [1:0]       MY_SEL  = 2'(DOM_IDX);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dom_state_t;

    dom_state_t       state_d, state_q;
    logic [CNT_W-1:0] voted;
    logic [CNT_W-1:0] nominal;
    logic             hit;

    // This domain's own voter, at the head of its feedback loop.
    tmr_voter #(.W(CNT_W)) u_voter (
        .a_i (all_q_i[0]),
        .b_i (all_q_i[1]),
        .c_i (all_q_i[2]),
        .y_o (voted)
    );

    always_comb begin
        state_d = state_q;
        hit     = inj_en_i && (inj_sel_i == MY_SEL);

        if (!en_i) begin
            nominal = voted;
        end else if (up_i) begin
            nominal = (voted == LAST) ? '0 : voted + 1'b1;
        end else begin
            nominal = (voted == '0) ? LAST : voted - 1'b1;
        end

        if (hit) begin
            if (inj_mode_e'(inj_mode_i) == INJ_FORCE) begin
                state_d.cnt = inj_val_i;
            end else begin
                state_d.cnt = nominal ^ inj_val_i;
            end
        end else begin
            state_d.cnt = nominal;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o        = state_q.cnt;
    assign mismatch_o = (state_q.cnt != voted);
endmodule

// File: rtl/tmr_voted_ctrl.sv
module tmr_voted_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned MAX_COUNT = 12,
    parameter int unsigned CNT_W     = $clog2(MAX_COUNT)
) (
    input  logic [2:0]            clk_i,
    input  logic [2:0]            rst_ni,
    input  logic [2:0]            en_i,
    input  logic [2:0]            up_i,
    input  logic                  inj_en_i,
    input  logic [1:0]            inj_sel_i,
    input  logic                  inj_mode_i,
    input  logic [CNT_W-1:0]      inj_val_i,
    output logic [2:0][CNT_W-1:0] state_o,
    output logic [2:0]            mismatch_o
);
    logic [NUM_DOM-1:0][CNT_W-1:0] dom_q;

    for (genvar k = 0; k < NUM_DOM; k++) begin : g_dom
        tmr_domain #(
            .MAX_COUNT (MAX_COUNT),
            .CNT_W     (CNT_W),
            .DOM_IDX   (k)
        ) u_domain (
            .clk_i      (clk_i[k]),
            .rst_ni     (rst_ni[k]),
            .en_i       (en_i[k]),
            .up_i       (up_i[k]),
            .inj_en_i   (inj_en_i),
            .inj_sel_i  (inj_sel_i),
            .inj_mode_i (inj_mode_i),
            .inj_val_i  (inj_val_i),
            .all_q_i    (dom_q),
            .q_o        (dom_q[k]),
            .mismatch_o (mismatch_o[k])
        );
    end

    assign state_o = dom_q;
endmodule

// File: rtl/tmr_voted_ctrl_chk.sv
module tmr_voted_ctrl_chk #(
    parameter int unsigned MAX_COUNT = 12,
    parameter int unsigned CNT_W     = $clog2(MAX_COUNT)
) (
    input logic [2:0]            clk_i,
    input logic [2:0]            rst_ni,
    input logic [2:0]            en_i,
    input logic [2:0]            up_i,
    input logic                  inj_en_i,
    input logic [1:0]            inj_sel_i,
    input logic [2:0][CNT_W-1:0] state_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_COUNT - 1);

    logic all_same;
    logic in_same;
    assign all_same = (state_o[0] == state_o[1]) && (state_o[1] == state_o[2]);
    assign in_same  = (en_i == 3'b000 || en_i == 3'b111) &&
                      (up_i == 3'b000 || up_i == 3'b111);

    always @(posedge clk_i[0]) begin
        if (!rst_ni[0]) begin
            AST_RESET_VAL: assert (state_o[0] == '0); // R1
        end
    end

    AST_COUNT_UP: assert property (@(posedge clk_i[0]) disable iff (rst_ni != 3'b111)
        (all_same && !inj_en_i && en_i == 3'b111 && up_i == 3'b111)
        |=> (state_o[0] == (($past(state_o[0]) == LAST) ? '0 : $past(state_o[0]) + 1'b1))); // R2

    AST_HOLD: assert property (@(posedge clk_i[0]) disable iff (rst_ni != 3'b111)
        (all_same && !inj_en_i && en_i == 3'b000)
        |=> ($stable(state_o[0]) && $stable(state_o[1]) && $stable(state_o[2]))); // R4

    AST_FAULT_OVERRULED: assert property (@(posedge clk_i[0]) disable iff (rst_ni != 3'b111)
        (all_same && in_same && inj_en_i)
        |=> (state_o[0] == state_o[1] || state_o[1] == state_o[2] || state_o[0] == state_o[2])); // R6

    AST_SEL_NONE: assert property (@(posedge clk_i[0]) disable iff (rst_ni != 3'b111)
        (in_same && inj_en_i && inj_sel_i == 2'd3)
        |=> ((state_o[0] == state_o[1]) && (state_o[1] == state_o[2]))); // R8

    AST_REALIGN: assert property (@(posedge clk_i[0]) disable iff (rst_ni != 3'b111)
        (in_same && !inj_en_i)
        |=> ((state_o[0] == state_o[1]) && (state_o[1] == state_o[2]))); // R9
endmodule

bind tmr_voted_ctrl tmr_voted_ctrl_chk #(
    .MAX_COUNT (MAX_COUNT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .up_i      (up_i),
    .inj_en_i  (inj_en_i),
    .inj_sel_i (inj_sel_i),
    .state_o   (state_o)
);

// File: tb/tmr_voted_ctrl_tb.sv
module tmr_voted_ctrl_tb;
    localparam int unsigned MAXC = 12;
    localparam int unsigned W    = $clog2(MAXC);

    logic            clk = 1'b0;
    logic [2:0]      rst_n = 3'b111;
    logic [2:0]      en = '0, up = '0;
    logic            inj_en = 1'b0;
    logic [1:0]      inj_sel = '0;
    logic            inj_mode = 1'b0;
    logic [W-1:0]    inj_val = '0;
    logic [2:0][W-1:0] state;
    logic [2:0]      mism;

    logic [2:0][W-1:0] exp_q;
    int errors = 0, checks = 0;
    string cur_req = "R1";

    tmr_voted_ctrl #(.MAX_COUNT(MAXC)) u_dut (
        .clk_i      ({3{clk}}),
        .rst_ni     (rst_n),
        .en_i       (en),
        .up_i       (up),
        .inj_en_i   (inj_en),
        .inj_sel_i  (inj_sel),
        .inj_mode_i (inj_mode),
        .inj_val_i  (inj_val),
        .state_o    (state),
        .mismatch_o (mism)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] maj(input logic [W-1:0] a, b, c);
        return (a & b) | (b & c) | (a & c);
    endfunction

    function automatic logic [W-1:0] nxt(input logic [W-1:0] v, input logic e, input logic u);
        if (!e) return v;
        if (u) return (v == W'(MAXC - 1)) ? '0 : v + 1'b1;
        return (v == '0) ? W'(MAXC - 1) : v - 1'b1;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check_all();
        logic [W-1:0] v;
        v = maj(exp_q[0], exp_q[1], exp_q[2]);
        for (int k = 0; k < 3; k++) begin
            check(cur_req, state[k], exp_q[k]);
            check("R10", W'(mism[k]), W'(exp_q[k] != v));
        end
    endtask

    // Drive at negedge, model at posedge, check at the following negedge.
    task automatic step(input logic [2:0] e, input logic [2:0] u, input logic [2:0] r,
                        input logic ie, input logic [1:0] sel, input logic md,
                        input logic [W-1:0] val);
        logic [W-1:0] v;
        logic [W-1:0] n;
        en = e; up = u; rst_n = r; inj_en = ie; inj_sel = sel; inj_mode = md; inj_val = val;
        @(posedge clk);
        v = maj(exp_q[0], exp_q[1], exp_q[2]);
        for (int k = 0; k < 3; k++) begin
            n = nxt(v, e[k], u[k]);
            if (ie && sel == 2'(k)) n = md ? (n ^ val) : val;
            exp_q[k] = r[k] ? n : '0;
        end
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end

    initial begin
        logic fault_prev;
        void'($urandom(32'h5eed_7a11));
        exp_q = '0;
        #2 rst_n = 3'b000;
        @(negedge clk); @(negedge clk);
        cur_req = "R1";
        check_all();
        step(3'b000, 3'b000, 3'b111, 0, 0, 0, 0);        // R1: released together

        cur_req = "R2";
        for (int i = 0; i < 14; i++) step(3'b111, 3'b111, 3'b111, 0, 0, 0, 0);
        cur_req = "R3";
        for (int i = 0; i < 16; i++) step(3'b111, 3'b000, 3'b111, 0, 0, 0, 0);
        cur_req = "R4";
        for (int i = 0; i < 4; i++)  step(3'b000, 3'b111, 3'b111, 0, 0, 0, 0);

        for (int d = 0; d < 3; d++) begin
            cur_req = "R6";
            step(3'b111, 3'b111, 3'b111, 1, 2'(d), 0, 4'd15);  // out-of-range force
            cur_req = "R9";
            step(3'b111, 3'b111, 3'b111, 0, 0, 0, 0);
            cur_req = "R7";
            step(3'b111, 3'b000, 3'b111, 1, 2'(d), 1, 4'b1010);
            cur_req = "R5";
            step(3'b000, 3'b000, 3'b111, 0, 0, 0, 0);
        end
        cur_req = "R8";
        step(3'b111, 3'b111, 3'b111, 1, 2'd3, 0, 4'd9);
        step(3'b111, 3'b111, 3'b111, 1, 2'd3, 1, 4'd5);

        cur_req = "R11";
        for (int i = 0; i < 5; i++) step(3'b111, 3'b111, 3'b101, 0, 0, 0, 0);
        step(3'b111, 3'b111, 3'b111, 0, 0, 0, 0);
        step(3'b111, 3'b111, 3'b111, 0, 0, 0, 0);

        cur_req = "R12";
        for (int i = 0; i < 4; i++) step(3'b011, 3'b111, 3'b111, 0, 0, 0, 0);
        step(3'b111, 3'b111, 3'b111, 0, 0, 0, 0);

        cur_req = "R5";
        fault_prev = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic e, u, ie, md;
            logic [2:0] ev, rv;
            logic [1:0] sel;
            logic [W-1:0] val;
            e = ($urandom % 4) != 0; u = $urandom % 2;
            ev = {3{e}}; rv = 3'b111; ie = 0; sel = 0; md = 0;
            val = W'($urandom);
            if (!fault_prev && ($urandom % 4 == 0)) begin
                int kind, d;
                kind = $urandom % 4; d = $urandom % 3;
                case (kind)
                    0: begin ie = 1; sel = 2'($urandom % 4); md = 0; end
                    1: begin ie = 1; sel = 2'($urandom % 4); md = 1; end
                    2: rv[d] = 1'b0;
                    default: ev[d] = ~e;
                endcase
                fault_prev = 1'b1;
            end else begin
                fault_prev = 1'b0;
            end
            step(ev, {3{u}}, rv, ie, sel, md, val);
        end
        summary();
    end
endmodule